// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the access address for a synchronous burst memory. When a load occurs, it captures a full external address. The two lowest bits of that address become the starting offset of a four-beat burst. Each later advance moves only those two bits to the next beat. The upper bits stay fixed until the next load.

A static order input selects one of two beat orders. In linear order the offset counts upward modulo four from the start. In interleaved order the offset is the start XORed with the beat count. An active-low clock enable freezes all state for as many cycles as needed, which stretches the current access.

The output is taken directly from registered state through a small offset map. A new address therefore appears on the cycle after the edge that loads it. After a deselect, the controller must issue a load before it advances again.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low and after its release, `addr_out` reads 0 until the first enabled edge.
- R2: On an enabled edge (`clk_en_n` = 0) with `adv_ld` = 0, `addr_out` equals the sampled `addr_in` after that edge, and the beat count restarts at 0.
- R3: On an enabled edge with `adv_ld` = 1, `addr_out[ADDR_W-1:2]` keeps its value and only bits [1:0] may change.
- R4: With `order_sel` = 0 (linear), beat n of a burst that starts at offset s presents offset (s + n) mod 4 in bits [1:0].
- R5: With `order_sel` = 1 (interleaved), beat n of a burst that starts at offset s presents offset s XOR n in bits [1:0].
- R6: An edge with `clk_en_n` = 1 changes no state, whatever `addr_in` and `adv_ld` carry.
- R7: After four advances the offset returns to the start value, and the same four-beat order then repeats without a new load.
- R8: `order_sel` acts combinationally on the current beat. Changing it re-maps the present offset without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address, sampled on a load |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new address |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current access address |

## Verification
The bench uses the default 17-bit address width. This reaches the top bit, so addresses such as 0x1FFFF and 0x0ABCD show that the upper field survives whole through every advance. All four start offsets are covered in both orders, along with full wraps past four beats. Frozen cycles are driven with loads and new addresses pending, and the order input is switched in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Linear order: count up from the start offset, wrapping at the beat field width
  function automatic logic [BEAT_W-1:0] lin_ofs(input logic [BEAT_W-1:0] start,
                                                input logic [BEAT_W-1:0] beat);
    return start + beat;
  endfunction

  // Interleaved order: beat count flips bits of the start offset
  function automatic logic [BEAT_W-1:0] ilv_ofs(input logic [BEAT_W-1:0] start,
                                                input logic [BEAT_W-1:0] beat);
    return start ^ beat;
  endfunction
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   base_hi_q,
  output logic [BEAT_W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi_q <= '0;
      start_q   <= '0;
    end else if (cap_en) begin
      base_hi_q <= addr_in[ADDR_W-1:BEAT_W];
      start_q   <= addr_in[BEAT_W-1:0];
    end
  end

  // Without a capture, the stored address must not move (R3, R6)
  assert_base_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(base_hi_q) && $stable(start_q)));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beat_q <= '0;
    else if (clr)  beat_q <= '0;
    else if (step) beat_q <= beat_q + 1'b1;
  end

  assert_beat_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (beat_q == '0));

  assert_beat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_seq_pkg::*;
#(
  parameter int NB = BEAT_W
) (
  input  logic [NB-1:0] start,
  input  logic [NB-1:0] beat,
  input  logic          order_sel,
  output logic [NB-1:0] ofs
);
  order_e ord;
  assign ord = order_e'(order_sel);

  always_comb begin
    unique case (ord)
      ORD_LINEAR:     ofs = lin_ofs(start, beat);
      ORD_INTERLEAVE: ofs = ilv_ofs(start, beat);
      default:        ofs = start;
    endcase
  end

  // On beat zero both orders present the start offset (R4, R5)
  always_comb begin
    if (beat == '0) assert_beat0_start_R4: assert (ofs == start);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv_ld,
  input  logic              clk_en_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - BEAT_W;

  // Named internal events for assertions
  logic fire_ev, load_ev, step_ev;
  assign fire_ev = !clk_en_n;
  assign load_ev = fire_ev && !adv_ld;
  assign step_ev = fire_ev && adv_ld;

  logic [HI_W-1:0]   base_hi_q;
  logic [BEAT_W-1:0] start_q, beat_q, ofs;

  burst_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk(clk), .rst_n(rst_n), .cap_en(load_ev), .addr_in(addr_in),
    .base_hi_q(base_hi_q), .start_q(start_q));

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .clr(load_ev), .step(step_ev), .beat_q(beat_q));

  burst_ofs_map #(.NB(BEAT_W)) u_map (
    .start(start_q), .beat(beat_q), .order_sel(order_sel), .ofs(ofs));

  assign addr_out = {base_hi_q, ofs};

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (addr_out == $past(addr_in)));

  assert_adv_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(base_hi_q) && $stable(start_q) && $stable(beat_q)));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              adv_ld = 1'b0;
  logic              clk_en_n = 1'b1;
  logic              order_sel = 1'b0;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [ADDR_W-3:0] m_hi = '0;
  logic [1:0]        m_start = '0;
  int                m_beat = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .adv_ld(adv_ld),
    .clk_en_n(clk_en_n), .order_sel(order_sel), .addr_out(addr_out));

  function automatic logic [ADDR_W-1:0] expect_addr();
    logic [1:0] o;
    if (order_sel) o = m_start ^ 2'(m_beat % 4);
    else           o = 2'((m_start + m_beat) % 4);
    return {m_hi, o};
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp_v);
    checks++;
    if (addr_out !== exp_v) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp_v);
    end
  endtask

  // One clock: drive at falling edge, sample 2 ns after the rising edge
  task automatic cyc(input logic [ADDR_W-1:0] a, input logic adv,
                     input logic cen, input string req);
    @(negedge clk);
    addr_in = a; adv_ld = adv; clk_en_n = cen;
    @(posedge clk);
    #2;
    if (rst_n && !cen) begin
      if (!adv) begin m_hi = a[ADDR_W-1:2]; m_start = a[1:0]; m_beat = 0; end
      else m_beat++;
    end
    check(req, expect_addr());
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(17'h1FFFF, 1'b0, 1'b0, "R1");
    cyc(17'h12345, 1'b0, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1; clk_en_n = 1'b1;
    #1 check("R1", '0);
  endtask

  task automatic t_load();
    order_sel = 1'b0;
    cyc(17'h1FFFF, 1'b0, 1'b0, "R2");
    check("R2", 17'h1FFFF);
    cyc(17'h0ABCD, 1'b0, 1'b0, "R2");
    check("R2", 17'h0ABCD);
    cyc(17'h00000, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_linear();
    order_sel = 1'b0;
    for (int s = 0; s < 4; s++) begin
      cyc({15'h5A5A, 2'(s)}, 1'b0, 1'b0, "R2");
      for (int n = 0; n < 3; n++) begin
        cyc(17'h0, 1'b1, 1'b0, "R4");
        checks++;
        if (addr_out[ADDR_W-1:2] !== 15'h5A5A) begin
          errors++;
          $display("FAIL R3: upper=%h expected=%h", addr_out[ADDR_W-1:2], 15'h5A5A);
        end
      end
    end
    // explicit example: start 1 -> 1,2,3,0
    cyc(17'h1FFFD, 1'b0, 1'b0, "R4");
    cyc(17'h0, 1'b1, 1'b0, "R4"); check("R4", 17'h1FFFE);
    cyc(17'h0, 1'b1, 1'b0, "R4"); check("R4", 17'h1FFFF);
    cyc(17'h0, 1'b1, 1'b0, "R4"); check("R4", 17'h1FFFC);
  endtask

  task automatic t_interleave();
    order_sel = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cyc({15'h2B3C, 2'(s)}, 1'b0, 1'b0, "R2");
      for (int n = 0; n < 3; n++) cyc(17'h0, 1'b1, 1'b0, "R5");
    end
    // start 1 -> 1,0,3,2
    cyc(17'h00401, 1'b0, 1'b0, "R5");
    cyc(17'h0, 1'b1, 1'b0, "R5"); check("R5", 17'h00400);
    cyc(17'h0, 1'b1, 1'b0, "R5"); check("R5", 17'h00403);
    cyc(17'h0, 1'b1, 1'b0, "R5"); check("R5", 17'h00402);
  endtask

  task automatic t_wrap();
    for (int o = 0; o < 2; o++) begin
      order_sel = 1'(o);
      cyc(17'h0F0F2, 1'b0, 1'b0, "R2");
      for (int n = 0; n < 4; n++) cyc(17'h0, 1'b1, 1'b0, "R7");
      check("R7", 17'h0F0F2);
      for (int n = 0; n < 5; n++) cyc(17'h0, 1'b1, 1'b0, "R7");
    end
  endtask

  task automatic t_freeze();
    order_sel = 1'b0;
    cyc(17'h13571, 1'b0, 1'b0, "R2");
    cyc(17'h0, 1'b1, 1'b0, "R4");
    for (int n = 0; n < 4; n++) begin
      cyc(17'h0AAAA + 17'(n), 1'b0, 1'b1, "R6");
      check("R6", 17'h13572);
      cyc(17'h0, 1'b1, 1'b1, "R6");
      check("R6", 17'h13572);
    end
    cyc(17'h0, 1'b1, 1'b0, "R6");
    check("R6", 17'h13573);
  endtask

  task automatic t_order_switch();
    order_sel = 1'b0;
    cyc(17'h02221, 1'b0, 1'b0, "R2");
    cyc(17'h0, 1'b1, 1'b0, "R4");
    check("R8", 17'h02222);
    @(negedge clk); clk_en_n = 1'b1; order_sel = 1'b1;
    #1 check("R8", 17'h02220);
    @(negedge clk); order_sel = 1'b0;
    #1 check("R8", 17'h02222);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_linear();
    t_interleave();
    t_wrap();
    t_freeze();
    t_order_switch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule